// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Tracker

This block follows one SDRAM bank through a stream of decoded commands and keeps the bank state and its timing. When a read or write arrives with the auto-precharge flag set, the block works out the clock edge at which the bank closes itself. It emits a one-cycle pulse on that edge and then counts out the precharge period. After that period it reports that the bank may be opened again.

A controller uses the outputs to schedule its next activate. A checker can use the violation flag to catch commands that break the protocol. A read with auto-precharge closes the bank CAS-latency-minus-one cycles before its last data beat, which is exactly the burst length after the command edge. A write closes the bank on the edge after its last data beat, which is the same edge. Both are held back if the minimum active time since the activate has not yet passed.

Top module: `sdram_bank_ap_tracker`

## Requirements
- R1: After reset the bank state is IDLE (code 0), `act_ready_o` is high, and `pre_start_o` and `viol_o` are low.
- R2: The command codes on `cmd_i` are NOP=0, ACT=1, RD=2, WR=3 and PRE=4; codes 5 to 7 act as NOP. The state codes are IDLE=0, ACTIVE=1, BURST=2, BURST_AP=3 and PRECHARGING=4. An ACT while `act_ready_o` is high moves the bank to ACTIVE on that edge.
- R3: A RD or WR with `ap_i` low, in ACTIVE or BURST, puts the bank in BURST for BURST_LEN edges, and it returns to ACTIVE on the BURST_LEN-th edge after the command. A new RD or WR during BURST restarts that window.
- R4: A RD or WR with `ap_i` high, in ACTIVE or BURST, puts the bank in BURST_AP. Provided tRAS is met, the precharge starts BURST_LEN edges after the command. From that edge the state is PRECHARGING and `pre_start_o` is high for exactly one cycle.
- R5: The precharge-start edge is never earlier than TRAS_MIN edges after the accepted ACT. It is the later of command+BURST_LEN and activate+TRAS_MIN.
- R6: `act_ready_o` rises so that an ACT on the TRP-th edge after the precharge start is accepted. An earlier ACT is not accepted. Without an ACT, the bank enters IDLE on that edge.
- R7: A PRE in ACTIVE or BURST moves the bank to PRECHARGING on that edge with no `pre_start_o` pulse, and the tRP count applies. A PRE in IDLE or PRECHARGING has no effect and raises no violation.
- R8: A RD, WR or PRE while in BURST_AP raises `viol_o` for one cycle and is otherwise ignored, so the precharge start is unchanged.
- R9: An ACT while `act_ready_o` is low raises `viol_o` for one cycle and changes nothing.
- R10: A RD or WR in IDLE or PRECHARGING raises `viol_o` for one cycle and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command to this bank |
| ap_i | input | 1 | Auto-precharge flag sampled with RD/WR |
| state_o | output | 3 | Bank state code |
| pre_start_o | output | 1 | One-cycle pulse at internal precharge start |
| act_ready_o | output | 1 | An ACT on the next edge is legal |
| viol_o | output | 1 | Illegal command seen on the previous edge |

## Verification
The bench sweeps the gap between the activate and an auto-precharge read or write across both sides of the tRAS boundary. A design that ignored tRAS would pulse early for short gaps. A design that added the delays instead of taking the later of the two would pulse late. The bench probes `act_ready_o` on each edge of the tRP window and issues an activate one edge early, which catches off-by-one errors in the precharge counter. It sends illegal commands into BURST_AP and checks that the close-out edge does not move. A design that acted on them would restart or end the burst. It also checks that a mid-burst read or write restarts a plain burst, and that an explicit precharge gives no start pulse.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE     = 3'd0,
    BK_ACTIVE   = 3'd1,
    BK_BURST    = 3'd2,
    BK_BURST_AP = 3'd3,
    BK_PRECH    = 3'd4
  } bank_state_e;
endpackage

// File: rtl/bank_down_cnt.sv
module bank_down_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/bank_cmd_check.sv
module bank_cmd_check
  import sdram_bank_pkg::*;
(
  input  bank_state_e state_i,
  input  logic [2:0]  cmd_i,
  input  logic        rp_zero_i,
  output logic        act_ready_o,
  output logic        legal_o
);
  logic closed;

  assign act_ready_o = (state_i == BK_IDLE) || (state_i == BK_PRECH && rp_zero_i);
  assign closed      = (state_i == BK_IDLE) || (state_i == BK_PRECH);

  always_comb begin
    legal_o = 1'b1;
    case (cmd_i)
      CMD_ACT:        legal_o = act_ready_o;
      CMD_RD, CMD_WR: legal_o = !closed && (state_i != BK_BURST_AP);
      CMD_PRE:        legal_o = (state_i != BK_BURST_AP);
      default:        legal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sdram_bank_ap_tracker.sv
module sdram_bank_ap_tracker
  import sdram_bank_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int TRAS_MIN  = 6,
  parameter int TRP       = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cmd_i,
  input  logic       ap_i,
  output logic [2:0] state_o,
  output logic       pre_start_o,
  output logic       act_ready_o,
  output logic       viol_o
);
  // edges from RD/WR to precharge start: read ends CL-1 before last beat, write after last beat
  localparam int RD_AP_OFS = (CAS_LAT + BURST_LEN - 1) - (CAS_LAT - 1);
  localparam int WR_AP_OFS = BURST_LEN;
  localparam int BST_MAX   = (RD_AP_OFS > WR_AP_OFS) ? RD_AP_OFS : WR_AP_OFS;
  localparam int BST_W     = (BST_MAX  > 1) ? $clog2(BST_MAX)  : 1;
  localparam int RAS_W     = (TRAS_MIN > 1) ? $clog2(TRAS_MIN) : 1;
  localparam int RP_W      = (TRP      > 1) ? $clog2(TRP)      : 1;

  bank_state_e state_q, state_d;
  logic pulse_q, pulse_d, viol_q, viol_d;
  logic legal, is_rw;
  logic ras_load, rp_load, bst_load;
  logic ras_zero, rp_zero, bst_zero;
  logic [BST_W-1:0] bst_val;

  bank_cmd_check u_chk (
    .state_i    (state_q),
    .cmd_i      (cmd_i),
    .rp_zero_i  (rp_zero),
    .act_ready_o(act_ready_o),
    .legal_o    (legal)
  );

  bank_down_cnt #(.W(RAS_W)) u_ras (
    .clk_i, .rst_ni, .load_i(ras_load),
    .load_val_i(RAS_W'(TRAS_MIN - 1)), .zero_o(ras_zero));

  bank_down_cnt #(.W(RP_W)) u_rp (
    .clk_i, .rst_ni, .load_i(rp_load),
    .load_val_i(RP_W'(TRP - 1)), .zero_o(rp_zero));

  bank_down_cnt #(.W(BST_W)) u_bst (
    .clk_i, .rst_ni, .load_i(bst_load),
    .load_val_i(bst_val), .zero_o(bst_zero));

  assign is_rw   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign bst_val = (cmd_i == CMD_RD) ? BST_W'(RD_AP_OFS - 1) : BST_W'(WR_AP_OFS - 1);

  always_comb begin
    state_d  = state_q;
    ras_load = 1'b0;
    rp_load  = 1'b0;
    bst_load = 1'b0;
    pulse_d  = 1'b0;
    viol_d   = !legal;
    case (state_q)
      BK_IDLE:
        if (cmd_i == CMD_ACT) begin
          state_d  = BK_ACTIVE;
          ras_load = 1'b1;
        end
      BK_ACTIVE, BK_BURST:
        if (legal && is_rw) begin
          state_d  = ap_i ? BK_BURST_AP : BK_BURST;
          bst_load = 1'b1;
        end else if (cmd_i == CMD_PRE) begin
          state_d  = BK_PRECH;
          rp_load  = 1'b1;
        end else if (state_q == BK_BURST && bst_zero) begin
          state_d  = BK_ACTIVE;
        end
      BK_BURST_AP:
        if (bst_zero && ras_zero) begin
          state_d  = BK_PRECH;
          rp_load  = 1'b1;
          pulse_d  = 1'b1;
        end
      BK_PRECH:
        if (cmd_i == CMD_ACT && legal) begin
          state_d  = BK_ACTIVE;
          ras_load = 1'b1;
        end else if (rp_zero) begin
          state_d  = BK_IDLE;
        end
      default: state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      pulse_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      viol_q  <= viol_d;
    end
  end

  assign state_o     = state_q;
  assign pre_start_o = pulse_q;
  assign viol_o      = viol_q;

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_start_o |=> !pre_start_o);
  assert_pulse_prech_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_start_o |-> state_q == BK_PRECH);
  assert_ras_met_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_start_o) |-> $past(ras_zero));
  assert_rp_met_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_ACTIVE && $past(state_q) == BK_PRECH) |-> $past(rp_zero));
  assert_ready_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_ready_o |-> (state_q == BK_IDLE || state_q == BK_PRECH));
  assert_ap_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_BURST_AP) |=> (state_q == BK_BURST_AP || state_q == BK_PRECH));
  assert_idle_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && $past(state_q) == BK_IDLE) |-> state_q == BK_IDLE);
endmodule

// File: tb/sdram_bank_ap_tracker_tb_top.sv
module sdram_bank_ap_tracker_tb_top;
  import sdram_bank_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BL = 4, CL = 3, TRAS = 6, TRP = 3;

  logic clk, rst_n, ap, pre_start, act_ready, viol;
  logic [2:0] cmd, state;
  int errs = 0, checks = 0, ec = 0;

  sdram_bank_ap_tracker #(.BURST_LEN(BL), .CAS_LAT(CL), .TRAS_MIN(TRAS), .TRP(TRP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ap_i(ap),
    .state_o(state), .pre_start_o(pre_start), .act_ready_o(act_ready), .viol_o(viol));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s edge=%0d actual=%0d expected=%0d", req, what, ec, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] c, input logic a);
    cmd = c; ap = a;
    @(posedge clk);
    @(negedge clk);
    ec++;
    cmd = CMD_NOP; ap = 1'b0;
  endtask

  task automatic do_reset();
    cmd = CMD_NOP; ap = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ec = 0;
  endtask

  task automatic st(input string req, input int exp);
    chk(state == 3'(exp), req, "state", state, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int a, e0, p, exp_p, guard;
    do_reset();
    st("R1", 0);
    chk(act_ready == 1'b1, "R1", "act_ready", act_ready, 1);
    chk(pre_start == 1'b0, "R1", "pre_start", pre_start, 0);
    chk(viol == 1'b0, "R1", "viol", viol, 0);

    // sweep activate-to-AP gap for read and write (R4, R5, R6)
    for (int wr = 0; wr < 2; wr++) begin
      for (int d = 0; d < 7; d++) begin
        do_reset();
        tick(CMD_ACT, 1'b0); a = ec;
        st("R2", 1);
        repeat (d) tick(3'd6, 1'b1);  // undefined code acts as NOP
        st("R2", 1);
        tick(wr ? CMD_WR : CMD_RD, 1'b1); e0 = ec;
        st("R4", 3);
        exp_p = (e0 + BL > a + TRAS) ? e0 + BL : a + TRAS;
        p = -1; guard = 0;
        while (p < 0 && guard < 40) begin
          tick(CMD_NOP, 1'b0); guard++;
          if (pre_start) p = ec;
        end
        chk(p == exp_p, (exp_p == e0 + BL) ? "R4" : "R5", "precharge start edge", p, exp_p);
        st("R4", 4);
        forever begin
          chk(act_ready == (ec + 1 >= p + TRP), "R6", "act_ready", act_ready, ec + 1 >= p + TRP);
          if (ec == p + 1) chk(pre_start == 1'b0, "R4", "pulse width", pre_start, 0);
          if (ec + 1 >= p + TRP) break;
          tick(CMD_NOP, 1'b0);
        end
        tick(CMD_ACT, 1'b0);
        st("R6", 1);
        chk(viol == 1'b0, "R6", "viol on timely ACT", viol, 0);
      end
    end

    // early ACT during tRP (R9)
    do_reset();
    tick(CMD_ACT, 1'b0);
    repeat (5) tick(CMD_NOP, 1'b0);
    tick(CMD_RD, 1'b1);                      // edge 7, start at 11
    repeat (4) tick(CMD_NOP, 1'b0);
    chk(pre_start == 1'b1, "R4", "pulse at 11", pre_start, 1);
    tick(CMD_ACT, 1'b0);                     // edge 12 < 11+TRP
    chk(viol == 1'b1, "R9", "early ACT viol", viol, 1);
    st("R9", 4);
    tick(CMD_NOP, 1'b0);
    chk(viol == 1'b0, "R9", "viol one cycle", viol, 0);
    chk(act_ready == 1'b1, "R6", "ready at 13", act_ready, 1);
    tick(CMD_ACT, 1'b0);
    st("R6", 1);

    // illegal commands inside BURST_AP (R8)
    for (int k = 0; k < 3; k++) begin
      do_reset();
      tick(CMD_ACT, 1'b0);
      repeat (5) tick(CMD_NOP, 1'b0);
      tick(CMD_WR, 1'b1); e0 = ec;
      tick((k == 0) ? CMD_RD : (k == 1) ? CMD_WR : CMD_PRE, k[0]);
      chk(viol == 1'b1, "R8", "viol in BURST_AP", viol, 1);
      st("R8", 3);
      p = -1; guard = 0;
      while (p < 0 && guard < 20) begin
        tick(CMD_NOP, 1'b0); guard++;
        if (pre_start) p = ec;
      end
      chk(p == e0 + BL, "R8", "start edge unchanged", p, e0 + BL);
    end

    // plain bursts and cut-short (R3)
    do_reset();
    tick(CMD_ACT, 1'b0);
    tick(CMD_RD, 1'b0); e0 = ec;
    for (int i = 0; i < BL; i++) begin
      st("R3", 2);
      tick(CMD_NOP, 1'b0);
    end
    st("R3", 1);
    tick(CMD_RD, 1'b0);
    tick(CMD_NOP, 1'b0);
    tick(CMD_WR, 1'b0); e0 = ec;
    for (int i = 0; i < BL; i++) begin
      st("R3", 2);
      chk(pre_start == 1'b0 && viol == 1'b0, "R3", "quiet burst", {pre_start, viol}, 0);
      tick(CMD_NOP, 1'b0);
    end
    st("R3", 1);

    // explicit precharge (R7) and closed-bank commands (R10, R9)
    tick(CMD_RD, 1'b0);
    tick(CMD_PRE, 1'b0); p = ec;
    st("R7", 4);
    chk(pre_start == 1'b0, "R7", "no pulse on PRE", pre_start, 0);
    tick(CMD_PRE, 1'b0);
    chk(viol == 1'b0, "R7", "PRE while precharging", viol, 0);
    chk(act_ready == 1'b0, "R7", "ready p+1", act_ready, 0);
    tick(CMD_NOP, 1'b0);
    chk(act_ready == 1'b1, "R7", "ready p+2", act_ready, 1);
    tick(CMD_NOP, 1'b0);
    st("R6", 0);
    tick(CMD_PRE, 1'b0);
    chk(viol == 1'b0, "R7", "PRE in IDLE", viol, 0);
    st("R7", 0);
    tick(CMD_RD, 1'b1);
    chk(viol == 1'b1, "R10", "RD in IDLE", viol, 1);
    st("R10", 0);
    tick(CMD_ACT, 1'b0);
    st("R2", 1);
    tick(CMD_ACT, 1'b0);
    chk(viol == 1'b1, "R9", "ACT in ACTIVE", viol, 1);
    st("R9", 1);
    tick(CMD_PRE, 1'b0);
    st("R7", 4);
    tick(CMD_WR, 1'b0);
    chk(viol == 1'b1, "R10", "WR while precharging", viol, 1);
    st("R10", 4);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule